// File: doc/BRIEF.md
# Serial Link Port Error and Status Register

This block is the 32-bit error and status word of one serial link port. The link state machines and the error counters feed it with condition signals. It registers those conditions into live status bits, keeps sticky "seen" copies of the error-stop and retry-stop conditions, and compares the degraded and failed error counts against thresholds that arrive on input ports. Software reads the word, and clears the sticky copies, over a simple register bus.

The word sits at offset 0x158 of the port register space. Software decodes each bit position, so those positions are fixed. A write at that offset clears only the sticky bits that have a 1 in the write data. Every bit that hardware owns follows the link logic alone.

Top module: `link_port_errstat`

## Requirements
- R1: After reset the word reads 0x00000001: bit 0 (port not initialized) is 1 and every other bit is 0.
- R2: Bit 1 is the registered port-ready input and bit 0 is its complement, so exactly one of the two bits is 1 in every cycle.
- R3: The live bits show the value their condition input had on the previous clock edge: bit 2 for an unrecoverable link error, bit 4 for a pending port-write notice, bit 8 for input error-stop, bit 10 for input retry-stop, bit 16 for output error-stop, bit 18 for output retry-stop, and bit 26 for a dropped outbound packet.
- R4: Bits 9, 17 and 19 are sticky copies of input error-stop, output error-stop and output retry-stop. Each bit becomes 1 on an edge where its condition input is 1. It goes back to 0 only on a write at offset 0x158 with a 1 in that bit position. A write with 0 in that position leaves it unchanged.
- R5: When a condition input is 1 on the same edge as a write-1 clear of its sticky bit, the bit stays 1.
- R6: Bit 20 becomes 1 on an edge where output retry-stop is 1. Only reset returns it to 0, and writes have no effect on it.
- R7: Bit 24 is 1 when the degraded count is greater than or equal to the degraded threshold, and bit 25 is 1 when the failed count is greater than or equal to the failed threshold. Both bits are sampled on the previous edge.
- R8: Writes have no effect on the hardware-owned bits or on the reserved bits. Writes at any address other than 0x158 have no effect at all.
- R9: The reserved bits (3, 5-7, 11-15, 21-23 and 27-31) always read 0.
- R10: Read data is registered. One cycle after the bus presents address 0x158, the read data shows the word as it was before that edge. For any other address the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 32 | Write data; each 1 clears the sticky bit in that position |
| bus_rdata | output | 32 | Registered read data |
| lnk_ok | input | 1 | Port initialized and exchanging clean control symbols |
| lnk_unrecov | input | 1 | Error the port cannot recover from in hardware |
| lnk_pw_pend | input | 1 | Port-write notification pending |
| lnk_in_err_stop | input | 1 | Input side in error-stop |
| lnk_in_retry_stop | input | 1 | Input side in retry-stop |
| lnk_out_err_stop | input | 1 | Output side in error-stop |
| lnk_out_retry_stop | input | 1 | Output side in retry-stop |
| lnk_pkt_drop | input | 1 | An outbound packet was dropped |
| degr_cnt | input | CNT_W | Degraded error count |
| degr_thr | input | CNT_W | Degraded error threshold |
| fail_cnt | input | CNT_W | Failed error count |
| fail_thr | input | CNT_W | Failed error threshold |

## Verification
The bench builds the block with CNT_W = 4, so random counts and thresholds are often equal or only one apart, which tests the greater-or-equal boundary of bits 24 and 25 many times. ADDR_W keeps its default of 12. Because of that, addresses that differ from 0x158 in only a few bits test that writes at other addresses are ignored and that reads there return 0. The random stimulus often drives a condition input to 1 in the same cycle as a write-1 clear, so the set-wins rule of the sticky bits is tested far more often than the directed collision case alone would test it.

// File: rtl/errstat_pkg.sv
package errstat_pkg;
  localparam int REG_W = 32;

  // bit positions decoded by software
  localparam int P_NOINIT    = 0;
  localparam int P_READY     = 1;
  localparam int P_UNRECOV   = 2;
  localparam int P_PW_PEND   = 4;
  localparam int P_IERR      = 8;
  localparam int P_IERR_SEEN = 9;
  localparam int P_IRETRY    = 10;
  localparam int P_OERR      = 16;
  localparam int P_OERR_SEEN = 17;
  localparam int P_ORETRY    = 18;
  localparam int P_ORTY_FLAG = 19;
  localparam int P_ORTY_EVER = 20;
  localparam int P_DEGR      = 24;
  localparam int P_FAIL      = 25;
  localparam int P_DROP      = 26;

  localparam int N_STICKY = 4;

  typedef struct packed {
    logic ready;
    logic unrecov;
    logic pw_pend;
    logic ierr;
    logic iretry;
    logic oerr;
    logic oretry;
    logic drop;
  } live_t;

  localparam logic [REG_W-1:0] USED_MASK =
    (REG_W'(1) << P_NOINIT)    | (REG_W'(1) << P_READY)     |
    (REG_W'(1) << P_UNRECOV)   | (REG_W'(1) << P_PW_PEND)   |
    (REG_W'(1) << P_IERR)      | (REG_W'(1) << P_IERR_SEEN) |
    (REG_W'(1) << P_IRETRY)    | (REG_W'(1) << P_OERR)      |
    (REG_W'(1) << P_OERR_SEEN) | (REG_W'(1) << P_ORETRY)    |
    (REG_W'(1) << P_ORTY_FLAG) | (REG_W'(1) << P_ORTY_EVER) |
    (REG_W'(1) << P_DEGR)      | (REG_W'(1) << P_FAIL)      |
    (REG_W'(1) << P_DROP);
endpackage

// File: rtl/errstat_sticky.sv
module errstat_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/errstat_thresh.sv
module errstat_thresh #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             hit_o
);
  always_ff @(posedge clk) begin
    if (rst) hit_o <= 1'b0;
    else     hit_o <= (cnt_i >= thr_i);
  end

  // R7
  reach_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_i >= thr_i) |=> hit_o);
  // R7
  below_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_i < thr_i) |=> !hit_o);
endmodule

// File: rtl/link_port_errstat.sv
module link_port_errstat
  import errstat_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter int              CNT_W    = 8,
  parameter logic [ADDR_W-1:0] REG_OFFS = ADDR_W'('h158)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             lnk_ok,
  input  logic             lnk_unrecov,
  input  logic             lnk_pw_pend,
  input  logic             lnk_in_err_stop,
  input  logic             lnk_in_retry_stop,
  input  logic             lnk_out_err_stop,
  input  logic             lnk_out_retry_stop,
  input  logic             lnk_pkt_drop,
  input  logic [CNT_W-1:0] degr_cnt,
  input  logic [CNT_W-1:0] degr_thr,
  input  logic [CNT_W-1:0] fail_cnt,
  input  logic [CNT_W-1:0] fail_thr
);
  localparam int STK_POS [N_STICKY] = '{P_IERR_SEEN, P_OERR_SEEN, P_ORTY_FLAG, P_ORTY_EVER};
  localparam bit STK_CLR [N_STICKY] = '{1'b1, 1'b1, 1'b1, 1'b0};

  live_t             live_q;
  logic              noinit_q;
  logic              degr_hit, fail_hit;
  logic [N_STICKY-1:0] stk_set, stk_clr, stk_q;
  logic              addr_hit, wr_hit;
  logic [REG_W-1:0]  word;

  assign addr_hit = (bus_addr == REG_OFFS);
  assign wr_hit   = bus_wr && addr_hit;

  // live, hardware-owned bits
  always_ff @(posedge clk) begin
    if (rst) begin
      live_q   <= '0;
      noinit_q <= 1'b1;
    end else begin
      noinit_q       <= !lnk_ok;
      live_q.ready   <= lnk_ok;
      live_q.unrecov <= lnk_unrecov;
      live_q.pw_pend <= lnk_pw_pend;
      live_q.ierr    <= lnk_in_err_stop;
      live_q.iretry  <= lnk_in_retry_stop;
      live_q.oerr    <= lnk_out_err_stop;
      live_q.oretry  <= lnk_out_retry_stop;
      live_q.drop    <= lnk_pkt_drop;
    end
  end

  assign stk_set = {lnk_out_retry_stop, lnk_out_retry_stop, lnk_out_err_stop, lnk_in_err_stop};

  for (genvar k = 0; k < N_STICKY; k++) begin : g_stk
    if (STK_CLR[k]) begin : g_w1c
      assign stk_clr[k] = wr_hit && (|(bus_wdata & (32'b1 << STK_POS[k])));
    end else begin : g_keep
      assign stk_clr[k] = 1'b0;
    end
    errstat_sticky i_stk (
      .clk   (clk),
      .rst   (rst),
      .set_i (stk_set[k]),
      .clr_i (stk_clr[k]),
      .q_o   (stk_q[k])
    );
  end

  errstat_thresh #(.CNT_W(CNT_W)) i_degr (
    .clk(clk), .rst(rst), .cnt_i(degr_cnt), .thr_i(degr_thr), .hit_o(degr_hit));
  errstat_thresh #(.CNT_W(CNT_W)) i_fail (
    .clk(clk), .rst(rst), .cnt_i(fail_cnt), .thr_i(fail_thr), .hit_o(fail_hit));

  always_comb begin
    word              = '0;
    word[P_NOINIT]    = noinit_q;
    word[P_READY]     = live_q.ready;
    word[P_UNRECOV]   = live_q.unrecov;
    word[P_PW_PEND]   = live_q.pw_pend;
    word[P_IERR]      = live_q.ierr;
    word[P_IRETRY]    = live_q.iretry;
    word[P_OERR]      = live_q.oerr;
    word[P_ORETRY]    = live_q.oretry;
    word[P_DROP]      = live_q.drop;
    word[P_DEGR]      = degr_hit;
    word[P_FAIL]      = fail_hit;
    for (int k = 0; k < N_STICKY; k++) word[STK_POS[k]] = stk_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst)           bus_rdata <= '0;
    else if (addr_hit) bus_rdata <= word;
    else               bus_rdata <= '0;
  end

  // R2
  state_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(word[1:0]) == 1);
  // R3
  ierr_follow_chk: assert property (@(posedge clk) disable iff (rst)
    lnk_in_err_stop |=> word[P_IERR]);
  // R6
  ever_keep_chk: assert property (@(posedge clk) disable iff (rst)
    word[P_ORTY_EVER] |=> word[P_ORTY_EVER]);
  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & ~USED_MASK) == '0);
  // R10
  other_addr_chk: assert property (@(posedge clk) disable iff (rst)
    !addr_hit |=> bus_rdata == '0);
endmodule

// File: tb/test_link_port_errstat.sv
module test_link_port_errstat;
  localparam int AW = 12;
  localparam int CW = 4;
  localparam logic [AW-1:0] OFFS = 12'h158;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = OFFS;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic ok = 0, unrec = 0, pw = 0, ies = 0, irs = 0, oes = 0, ors = 0, drop = 0;
  logic [CW-1:0] dc = 0, dt = 1, fc = 0, ft = 1;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  link_port_errstat #(.ADDR_W(AW), .CNT_W(CW), .REG_OFFS(OFFS)) i_link_port_errstat (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lnk_ok(ok),
    .lnk_unrecov(unrec), .lnk_pw_pend(pw), .lnk_in_err_stop(ies),
    .lnk_in_retry_stop(irs), .lnk_out_err_stop(oes), .lnk_out_retry_stop(ors),
    .lnk_pkt_drop(drop), .degr_cnt(dc), .degr_thr(dt), .fail_cnt(fc), .fail_thr(ft));

  // behavioural reference: expected word and expected read data
  logic [31:0] m_word = 32'h1, m_rd = '0;
  always @(posedge clk) begin
    logic [31:0] nx;
    bit hit;
    if (rst) begin
      m_word = 32'h1;
      m_rd   = '0;
    end else begin
      hit  = bus_wr && (bus_addr == OFFS);
      m_rd = (bus_addr == OFFS) ? m_word : 32'h0;
      nx = '0;
      nx[0]  = !ok;   nx[1]  = ok;    nx[2]  = unrec; nx[4]  = pw;
      nx[8]  = ies;   nx[10] = irs;   nx[16] = oes;   nx[18] = ors;
      nx[26] = drop;
      nx[24] = (dc >= dt);
      nx[25] = (fc >= ft);
      nx[9]  = ies | (m_word[9]  & !(hit && bus_wdata[9]));
      nx[17] = oes | (m_word[17] & !(hit && bus_wdata[17]));
      nx[19] = ors | (m_word[19] & !(hit && bus_wdata[19]));
      nx[20] = ors | m_word[20];
      m_word = nx;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // wait for the next falling edge and compare every field group
  task automatic tick();
    @(negedge clk);
    if (!rst) begin
      chk("R2 state pair", bus_rdata & 32'h3, m_rd & 32'h3);
      chk("R3 live bits",  bus_rdata & 32'h0405_0514, m_rd & 32'h0405_0514);
      chk("R4 sticky w1c", bus_rdata & 32'h000A_0200, m_rd & 32'h000A_0200);
      chk("R6 ever bit",   bus_rdata & 32'h0010_0000, m_rd & 32'h0010_0000);
      chk("R7 thresholds", bus_rdata & 32'h0300_0000, m_rd & 32'h0300_0000);
      chk("R9 reserved",   bus_rdata & 32'hF8E0_F8E8, 32'h0);
    end
  endtask

  task automatic idle_inputs();
    {ok, unrec, pw, ies, irs, oes, ors, drop} = '0;
    dc = 0; dt = 1; fc = 0; ft = 1;
    bus_wr = 0; bus_wdata = '0; bus_addr = OFFS;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    rst = 0;
    tick();
    chk("R1 reset value", bus_rdata, 32'h0000_0001);

    // R8: write all ones with every condition low
    bus_wr = 1; bus_wdata = 32'hFFFF_FFFF;
    tick();
    bus_wr = 0; bus_wdata = '0;
    tick();
    tick();
    chk("R8 write ignored", bus_rdata, 32'h0000_0001);

    // R5 collision: set and write-1 clear of bit 9 on one edge
    ies = 1; bus_wr = 1; bus_wdata = 32'h0000_0200;
    tick();
    ies = 0; bus_wr = 0; bus_wdata = '0;
    tick();
    chk("R5 set wins", bus_rdata & 32'h200, 32'h200);
    // R4 write 0 keeps, write 1 clears
    bus_wr = 1; bus_wdata = 32'h0;
    tick();
    bus_wr = 1; bus_wdata = 32'h0000_0200;
    tick();
    chk("R4 zero write keeps", bus_rdata & 32'h200, 32'h200);
    bus_wr = 0; bus_wdata = '0;
    tick();
    chk("R4 one write clears", bus_rdata & 32'h200, 32'h0);

    // R6: bit 20 survives a write of ones
    ors = 1;
    tick();
    ors = 0; bus_wr = 1; bus_wdata = 32'hFFFF_FFFF;
    tick();
    bus_wr = 0; bus_wdata = '0;
    tick();
    chk("R6 ever survives write", bus_rdata & 32'h0010_0000, 32'h0010_0000);

    // R7 boundary: equal counts
    dc = 4'd7; dt = 4'd7; fc = 4'd6; ft = 4'd7;
    tick();
    tick();
    chk("R7 equal and below", bus_rdata & 32'h0300_0000, 32'h0100_0000);

    // R10: other address reads 0 and write there is ignored
    ies = 1;
    tick();
    ies = 0; bus_addr = OFFS ^ 12'h004; bus_wr = 1; bus_wdata = 32'hFFFF_FFFF;
    tick();
    chk("R10 other address reads zero", bus_rdata, 32'h0);
    bus_addr = OFFS; bus_wr = 0; bus_wdata = '0;
    tick();
    tick();
    chk("R8 other address write ignored", bus_rdata & 32'h200, 32'h200);

    // random traffic compared against the reference every cycle
    for (int i = 0; i < 4000; i++) begin
      {ok, unrec, pw, ies, irs, oes, ors, drop} = 8'($urandom);
      ies = ies & ($urandom_range(0, 3) == 0);
      oes = oes & ($urandom_range(0, 3) == 0);
      ors = ors & ($urandom_range(0, 3) == 0);
      dc = CW'($urandom); dt = CW'($urandom);
      fc = CW'($urandom); ft = CW'($urandom);
      bus_wr    = ($urandom_range(0, 2) == 0);
      bus_wdata = $urandom;
      bus_addr  = ($urandom_range(0, 9) == 0) ? (OFFS ^ AW'($urandom_range(1, 255))) : OFFS;
      if (i % 500 == 250) begin
        rst = 1;
        tick();
        rst = 0;
      end
      tick();
      chk("R10 read data", bus_rdata, m_rd);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule